// File: doc/BRIEF.md
# Parallel IO Pin Bank

A bank of 32 pads. For each pad, software chooses whether the general-purpose IO logic owns it or one of four on-chip peripheral functions owns it. Software also controls the output enable and output value, pull-up and pull-down, and open-drain (multi-drive) operation. Every control is a single state vector. Each vector has a set address and a clear address, and each takes a write mask. A bit that is 1 in the mask updates the matching pin. A bit that is 0 leaves that pin alone. Software therefore never needs read-modify-write, and two drivers can share a bank without locking.

A third address in each control group reads back the current state vector. One further address always returns the live level on the pads, whoever owns them. The pad drive is a per-pin multiplexer:

- When a pin is IO-owned, the IO data and output-enable registers drive the pad.
- When a pin is peripheral-owned, the pad takes the data and enable of the peripheral chosen by a two-bit code. That code is built from two select vectors.
- When open-drain mode is on, a pin whose driven value is 1 is released instead of driven high.

Top module: `pio_bank`

## Requirements
- R1: After reset, all pins are IO-owned (ownership 1 = IO) with output enable 0 and output data 0. Pull-up is 1 on every pin, and pull-down, multi-drive and both select vectors are 0.
- R2: A write to a control's set address (byte offset 0x00 within its 16-byte group) sets exactly the pins whose mask bit is 1. All other pins are unchanged. The new state shows from the cycle after the write. The groups are: ownership 0x00, output enable 0x10, output data 0x20, pull-up 0x30, pull-down 0x40, multi-drive 0x50, select-low 0x60 and select-high 0x70.
- R3: A write to a control's clear address (group offset 0x04) clears exactly the pins whose mask bit is 1. All other pins are unchanged.
- R4: Reading group offset 0x08 returns that control's state vector. Reads of the set and clear addresses, and of any address at 0x80 or above, return zero.
- R5: A read of address 0x7C returns `pad_in`, whatever the ownership of the pins.
- R6: Pull-up and pull-down are never both active on a pin. Setting pull-down clears pull-up on the masked pins, and setting pull-up clears pull-down on the masked pins.
- R7: On an IO-owned pin, `pad_out` follows the output-data bit and `pad_oe` follows the output-enable bit, subject to R9.
- R8: On a peripheral-owned pin, the code {select-high bit, select-low bit} picks the function. The codes are 00 = A, 01 = B, 10 = C and 11 = D. The chosen function's data and enable drive `pad_out` and `pad_oe`, subject to R9.
- R9: With multi-drive set on a pin, `pad_oe` is 0 whenever the driven value is 1. `pad_out` keeps the driven value.
- R10: `pad_pu` and `pad_pd` equal the pull-up and pull-down state vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| fn_a_dat | input | 32 | Function A output value, per pin |
| fn_b_dat | input | 32 | Function B output value, per pin |
| fn_c_dat | input | 32 | Function C output value, per pin |
| fn_d_dat | input | 32 | Function D output value, per pin |
| fn_a_oe | input | 32 | Function A drive enable, per pin |
| fn_b_oe | input | 32 | Function B drive enable, per pin |
| fn_c_oe | input | 32 | Function C drive enable, per pin |
| fn_d_oe | input | 32 | Function D drive enable, per pin |
| pad_in | input | 32 | Live pad levels |
| pad_out | output | 32 | Value presented to the pads |
| pad_oe | output | 32 | Pad driver enable |
| pad_pu | output | 32 | Pull-up enable per pad |
| pad_pd | output | 32 | Pull-down enable per pad |

## Verification
The set and clear assertions assume that at most one register write occurs per cycle. This is what keeps a set and a clear from ever targeting the same control at once. The stimulus meets this assumption because every access goes through a single write task that raises the strobe for exactly one cycle.

The pad-drive assertions assume nothing about the peripheral inputs. The bench holds those inputs steady while it samples the pads, so every pad check is made against a known selection.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NCTL = 8;

  typedef enum logic [2:0] {
    CTL_OWN  = 3'd0,
    CTL_OE   = 3'd1,
    CTL_DAT  = 3'd2,
    CTL_PU   = 3'd3,
    CTL_PD   = 3'd4,
    CTL_MD   = 3'd5,
    CTL_SEL0 = 3'd6,
    CTL_SEL1 = 3'd7
  } ctl_e;

  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_CLR  = 2'd1,
    OP_STAT = 2'd2,
    OP_AUX  = 2'd3
  } op_e;

  // controls whose reset state is all ones
  function automatic logic ctl_reset_ones(input int c);
    return (c == int'(CTL_OWN)) || (c == int'(CTL_PU));
  endfunction

  // open-drain rule: a driven 1 is released when multi-drive is on
  function automatic logic od_enable(input logic en, input logic md, input logic val);
    return en & ~(md & val);
  endfunction

  // next state of a set/clear vector
  function automatic logic [31:0] setclr_next(input logic [31:0] q, input logic [31:0] s,
                                              input logic [31:0] c);
    return (q | s) & ~c;
  endfunction
endpackage

// File: rtl/pio_setclr_reg.sv
module pio_setclr_reg
  import pio_pkg::*;
#(
  parameter int   W        = 32,
  parameter logic RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ext_clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VAL = RST_ONES ? '1 : '0;

  logic [W-1:0] set_mask, clr_mask;
  logic [31:0]  nxt32;

  assign set_mask = set_we ? wdata : '0;
  assign clr_mask = (clr_we ? wdata : '0) | ext_clr;
  assign nxt32    = setclr_next(32'(q), 32'(set_mask), 32'(clr_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= nxt32[W-1:0];
  end

  // R1: state right after reset release
  a_r1_reset_val: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == RST_VAL);
  // R2: masked bits become one after a set write
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((q & $past(wdata & ~ext_clr)) == $past(wdata & ~ext_clr)));
  // R2: unmasked bits keep their value
  a_r2_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we && ext_clr == '0) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
  // R3: masked bits become zero after a clear write
  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(wdata)) == '0));
  // R3: no write and no cross clear, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we && ext_clr == '0) |=> $stable(q));
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux
  import pio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        own,
  input  logic [W-1:0]        oe,
  input  logic [W-1:0]        dat,
  input  logic [W-1:0]        md,
  input  logic [W-1:0]        sel0,
  input  logic [W-1:0]        sel1,
  input  logic [3:0][W-1:0]   fn_dat,
  input  logic [3:0][W-1:0]   fn_oe,
  output logic [W-1:0]        pad_out,
  output logic [W-1:0]        pad_oe
);
  logic [W-1:0] drv_val, drv_en;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] code;
    logic       f_val, f_en;
    assign code = {sel1[i], sel0[i]};
    always_comb begin
      f_val = fn_dat[code][i];
      f_en  = fn_oe[code][i];
    end
    assign drv_val[i] = own[i] ? dat[i] : f_val;
    assign drv_en[i]  = own[i] ? oe[i]  : f_en;
    assign pad_out[i] = drv_val[i];
    assign pad_oe[i]  = od_enable(drv_en[i], md[i], drv_val[i]);

    // R9: an open-drain pin is never driven high
    a_r9_no_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
      (md[i] && pad_oe[i]) |-> !pad_out[i]);
    // R7: an IO-owned pin presents the data register value
    a_r7_io_value: assert property (@(posedge clk) disable iff (!rst_n)
      own[i] |-> pad_out[i] == dat[i]);
    // R8: a peripheral-owned pin never drives unless its function asks
    a_r8_fn_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!own[i] && pad_oe[i]) |-> fn_oe[code][i]);
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] fn_a_dat,
  input  logic [NPINS-1:0] fn_b_dat,
  input  logic [NPINS-1:0] fn_c_dat,
  input  logic [NPINS-1:0] fn_d_dat,
  input  logic [NPINS-1:0] fn_a_oe,
  input  logic [NPINS-1:0] fn_b_oe,
  input  logic [NPINS-1:0] fn_c_oe,
  input  logic [NPINS-1:0] fn_d_oe,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd
);
  localparam int HI_LSB = 7;

  // address fields
  logic       in_map;
  ctl_e       ctl_idx;
  op_e        op;
  logic       wr_set, wr_clr;
  logic       unused_lsb;

  assign in_map     = (bus_addr[AW-1:HI_LSB] == '0);
  assign ctl_idx    = ctl_e'(bus_addr[6:4]);
  assign op         = op_e'(bus_addr[3:2]);
  assign unused_lsb = ^bus_addr[1:0];
  assign wr_set     = bus_wr && in_map && (op == OP_SET);
  assign wr_clr     = bus_wr && in_map && (op == OP_CLR);

  // cross clears keeping pull-up and pull-down exclusive
  logic [NCTL-1:0][NPINS-1:0] ext_clr;
  always_comb begin
    ext_clr = '0;
    if (wr_set && ctl_idx == CTL_PD) ext_clr[CTL_PU] = bus_wdata;
    if (wr_set && ctl_idx == CTL_PU) ext_clr[CTL_PD] = bus_wdata;
  end

  logic [NCTL-1:0][NPINS-1:0] ctl_q;

  for (genvar c = 0; c < NCTL; c++) begin : g_ctl
    pio_setclr_reg #(
      .W       (NPINS),
      .RST_ONES(ctl_reset_ones(c))
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_set && (ctl_idx == ctl_e'(c))),
      .clr_we (wr_clr && (ctl_idx == ctl_e'(c))),
      .wdata  (bus_wdata),
      .ext_clr(ext_clr[c]),
      .q      (ctl_q[c])
    );
  end

  // named state vectors
  logic [NPINS-1:0] own_q, oe_q, dat_q, pu_q, pd_q, md_q, sel0_q, sel1_q;
  assign own_q  = ctl_q[CTL_OWN];
  assign oe_q   = ctl_q[CTL_OE];
  assign dat_q  = ctl_q[CTL_DAT];
  assign pu_q   = ctl_q[CTL_PU];
  assign pd_q   = ctl_q[CTL_PD];
  assign md_q   = ctl_q[CTL_MD];
  assign sel0_q = ctl_q[CTL_SEL0];
  assign sel1_q = ctl_q[CTL_SEL1];

  pio_pin_mux #(.W(NPINS)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .own    (own_q),
    .oe     (oe_q),
    .dat    (dat_q),
    .md     (md_q),
    .sel0   (sel0_q),
    .sel1   (sel1_q),
    .fn_dat ({fn_d_dat, fn_c_dat, fn_b_dat, fn_a_dat}),
    .fn_oe  ({fn_d_oe, fn_c_oe, fn_b_oe, fn_a_oe}),
    .pad_out(pad_out),
    .pad_oe (pad_oe)
  );

  assign pad_pu = pu_q;
  assign pad_pd = pd_q;

  // read path
  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      if (op == OP_STAT)                               bus_rdata = ctl_q[ctl_idx];
      else if (op == OP_AUX && ctl_idx == CTL_SEL1)    bus_rdata = pad_in;
    end
  end

  // R6: pulls are mutually exclusive
  a_r6_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);
  // R6: a pull-down set drops the pull-up on the masked pins
  a_r6_pd_drops_pu: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && ctl_idx == CTL_PD) |=> ((pad_pu & $past(bus_wdata)) == '0));
  // R4: set and clear addresses read as zero
  a_r4_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET || op == OP_CLR) |-> bus_rdata == '0);
endmodule

// File: tb/test_pio_bank.sv
module test_pio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [3:0]  rq;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] ex;
  } vec_t;

  // write, then read a status address and compare
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd2, 8'h10, 32'h000000FF, 8'h18, 32'h000000FF},  // R2 output enable set
    '{4'd3, 8'h14, 32'h0000000F, 8'h18, 32'h000000F0},  // R3 output enable clear
    '{4'd2, 8'h20, 32'hA5A50000, 8'h28, 32'hA5A50000},  // R2 data set
    '{4'd3, 8'h24, 32'hFF000000, 8'h28, 32'h00A50000},  // R3 data clear
    '{4'd6, 8'h40, 32'h0000FFFF, 8'h38, 32'hFFFF0000},  // R6 pull-down drops pull-up
    '{4'd6, 8'h30, 32'h000000F0, 8'h48, 32'h0000FF0F},  // R6 pull-up drops pull-down
    '{4'd3, 8'h34, 32'h0F000000, 8'h38, 32'hF0FF00F0},  // R3 pull-up clear
    '{4'd3, 8'h04, 32'hFFFF0000, 8'h08, 32'h0000FFFF},  // R3 hand pins to peripherals
    '{4'd2, 8'h60, 32'h00FF0000, 8'h68, 32'h00FF0000},  // R2 select-low set
    '{4'd2, 8'h70, 32'hF0F00000, 8'h78, 32'hF0F00000},  // R2 select-high set
    '{4'd2, 8'h50, 32'h80000001, 8'h58, 32'h80000001},  // R2 multi-drive set
    '{4'd4, 8'h10, 32'h00000000, 8'h10, 32'h00000000}   // R4 set address reads zero
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] fn_a_dat = '0, fn_b_dat = '0, fn_c_dat = '0, fn_d_dat = '0;
  logic [31:0] fn_a_oe = '1, fn_b_oe = '1, fn_c_oe = '1, fn_d_oe = '1;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

  int checks = 0;
  int errs = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_bank i_pio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fn_a_dat(fn_a_dat), .fn_b_dat(fn_b_dat), .fn_c_dat(fn_c_dat), .fn_d_dat(fn_d_dat),
    .fn_a_oe(fn_a_oe), .fn_b_oe(fn_b_oe), .fn_c_oe(fn_c_oe), .fn_d_oe(fn_d_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle write, ends just after the following falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h08, r); chk("R1 ownership", r, 32'hFFFFFFFF);
    rd(8'h18, r); chk("R1 output enable", r, 32'h0);
    rd(8'h38, r); chk("R1 pull-up", r, 32'hFFFFFFFF);
    rd(8'h48, r); chk("R1 pull-down", r, 32'h0);
    rd(8'h58, r); chk("R1 multi-drive", r, 32'h0);
    rd(8'h68, r); chk("R1 select-low", r, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k].wa, VEC[k].wd);
      rd(VEC[k].ra, r);
      checks++;
      if (r !== VEC[k].ex) begin
        errs++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[k].rq, k, r, VEC[k].ex);
      end
    end

    // R10 pull pins follow state
    chk("R10 pad_pu", pad_pu, 32'hF0FF00F0);
    chk("R10 pad_pd", pad_pd, 32'h0000FF0F);

    // R4 other reads
    rd(8'h04, r); chk("R4 clear address", r, 32'h0);
    rd(8'h80, r); chk("R4 unmapped", r, 32'h0);

    // R5 live pad level, mixed ownership
    pad_in = 32'h5A5A1234;
    rd(8'h7C, r); chk("R5 pad level", r, 32'h5A5A1234);

    // R8 function select: 16 -> B, 20 -> D, 24 -> A, 28 -> C
    fn_a_dat = 32'h01000000; fn_b_dat = 32'h00010000;
    fn_c_dat = 32'h10000000; fn_d_dat = 32'h00100000;
    #1;
    chk("R8 select data", pad_out & 32'h11110000, 32'h11110000);
    chk("R8 select enable", pad_oe & 32'h11110000, 32'h11110000);
    fn_b_oe = 32'h0;
    #1;
    chk("R8 function B enable off", {31'b0, pad_oe[16]}, 32'h0);

    // R7 IO-owned pins 4 (enabled, data 0) and 0 (not enabled)
    chk("R7 pin4 drive", {30'b0, pad_oe[4], pad_out[4]}, 32'h2);
    chk("R7 pin0 idle", {31'b0, pad_oe[0]}, 32'h0);

    // R9 open-drain on pin 0
    wr(8'h10, 32'h1);
    wr(8'h20, 32'h1);
    chk("R9 high released", {30'b0, pad_oe[0], pad_out[0]}, 32'h1);
    wr(8'h24, 32'h1);
    chk("R9 low driven", {30'b0, pad_oe[0], pad_out[0]}, 32'h2);

    // R1 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h08, r); chk("R1 ownership after reset", r, 32'hFFFFFFFF);
    chk("R1 pull-up after reset", pad_pu, 32'hFFFFFFFF);

    finish_run();
  end
endmodule